// File: doc/BRIEF.md
# Parallel SCSI Initiator Bus Register Block

This block connects a host processor to a single-ended parallel SCSI bus through eight byte-wide registers. It has a 3-bit address, an 8-bit data path and separate read and write strobes. The host sets control lines (RST, ACK, BSY, SEL, ATN) and the outgoing data byte through registers, and it reads the live bus levels back. Several addresses mean one thing when read and another when written. A write to some addresses is a command that carries no data.

The block compares the live MSG, CD and IO lines with a programmed expected phase. It raises an interrupt on selection, on a parity error, on an unexpected loss of BSY and on a phase mismatch during DMA. It also runs a byte-wide REQ/ACK handshake in both directions, pacing the host with a DRQ line, either one byte at a time or for a whole block. All bus inputs are taken as synchronous, active-high levels that include whatever the block drives itself.

Top module: `scsi_ini_regs`

## Requirements
- R1: A read strobe loads `hst_rdata` at the next clock edge, and the value holds until the next read. Address 1 reads the control bits (7 = RST, 4 = ACK, 3 = BSY, 2 = SEL, 1 = ATN, 0 = data enable), with bit 6 set while mode bit 0 (arbitrate) is set and bit 5 always 0. Addresses 2 and 3 read back the mode byte and the 4-bit phase byte. Address 7 reads 0x00. Every register resets to zero.
- R2: Address 4 reads the bus levels RST, BSY, REQ, MSG, CD, IO, SEL and data parity in bits 7 down to 0.
- R3: Address 5 bit 3 is 1 exactly when bus {MSG, CD, IO} equals phase register bits [2:0].
- R4: `db_oe` is high while mode bit 0 is set. It is also high while the phase matches and either control bit 0 is set or a DMA send is active. `db_out` is the byte last written to address 0, and `dbp_out` makes the parity of the nine lines odd.
- R5: `rst_o`, `bsy_o`, `sel_o` and `atn_o` follow control bits 7, 3, 2 and 1. `ack_o` is control bit 4 ORed with the DMA handshake acknowledge.
- R6: The interrupt flag sets when BSY is low, SEL is high and a data line that is enabled in the select mask (written at address 4) is high.
- R7: With mode bit 2 set, a high-to-low change of BSY sets the busy-error flag (address 5 bit 2) and the interrupt flag.
- R8: A read of address 7 clears the parity-error flag, the busy-error flag and the interrupt flag (address 5 bits 5, 2 and 4). If a flag's set condition is present in the same cycle, that flag stays set.
- R9: Only while mode bit 1 is set, a write to address 7 starts a receive. With no byte pending and the phase matching, an asserted REQ latches the data into address 6, makes a byte pending and asserts ACK until REQ drops. A read of address 6 removes the pending byte. DRQ shows a pending byte.
- R10: Only while mode bit 1 is set, a write to address 5 starts a send. DRQ is high while no byte is loaded. A write to address 0 loads a byte. An asserted REQ with a byte loaded drives the data and asserts ACK until REQ drops, and the byte is then used up.
- R11: With mode bit 7 set, DRQ stays high for as long as a DMA transfer is active.
- R12: A phase mismatch during an active transfer ends it, drops DRQ and sets the interrupt flag.
- R13: A write of the mode register with bit 1 clear ends an active transfer and sets address 5 bit 7. Starting a transfer clears that bit.
- R14: With mode bit 5 set, a received byte whose nine lines have even parity sets the parity-error flag (address 5 bit 5). With mode bit 4 also set, it sets the interrupt flag as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 3 | Register address |
| hst_wdata | input | 8 | Write data |
| hst_wr | input | 1 | Write strobe |
| hst_rd | input | 1 | Read strobe |
| hst_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | DMA request |
| bus_db_in | input | 8 | Bus data levels |
| bus_dbp_in | input | 1 | Bus parity level |
| bus_rst_in | input | 1 | Bus RST level |
| bus_bsy_in | input | 1 | Bus BSY level |
| bus_sel_in | input | 1 | Bus SEL level |
| bus_atn_in | input | 1 | Bus ATN level |
| bus_ack_in | input | 1 | Bus ACK level |
| bus_req_in | input | 1 | Bus REQ level |
| bus_msg_in | input | 1 | Bus MSG level |
| bus_cd_in | input | 1 | Bus CD level |
| bus_io_in | input | 1 | Bus IO level |
| db_out | output | 8 | Data to drive |
| dbp_out | output | 1 | Parity to drive |
| db_oe | output | 1 | Data and parity drive enable |
| rst_o | output | 1 | Drive RST |
| bsy_o | output | 1 | Drive BSY |
| sel_o | output | 1 | Drive SEL |
| atn_o | output | 1 | Drive ATN |
| ack_o | output | 1 | Drive ACK |

## Verification
The interrupt flag can be set and cleared in the same cycle. This happens when a read of address 7 lands while a selection condition is still on the bus. The bench provokes it by holding SEL, an enabled data line and an inactive BSY through the clearing read, and it expects the flag to stay set. It then repeats the read with the bus quiet and expects the flag to clear. A host read of address 6 can also meet an incoming REQ in the same cycle. The bench holds REQ high while a byte is pending and expects the second byte to be latched only in the cycle after the read.

// File: rtl/scsi_ini_pkg.sv
package scsi_ini_pkg;
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_ICMD  = 3'd1;
  localparam logic [2:0] A_MODE  = 3'd2;
  localparam logic [2:0] A_TCMD  = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;
  localparam logic [2:0] A_BSTAT = 3'd5;
  localparam logic [2:0] A_IDATA = 3'd6;
  localparam logic [2:0] A_CLR   = 3'd7;

  localparam int M_ARB    = 0;
  localparam int M_DMA    = 1;
  localparam int M_BSYMON = 2;
  localparam int M_PARINT = 4;
  localparam int M_PARCHK = 5;
  localparam int M_BLOCK  = 7;

  localparam int I_DATA = 0;
  localparam int I_ATN  = 1;
  localparam int I_SEL  = 2;
  localparam int I_BSY  = 3;
  localparam int I_ACK  = 4;
  localparam int I_RST  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX_WAIT, ST_RX_ACK, ST_TX_WAIT, ST_TX_ACK
  } dma_st_t;
endpackage

// File: rtl/scsi_ini_hostregs.sv
module scsi_ini_hostregs #(
  parameter int DW = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_odr,
  input  logic          wr_icr,
  input  logic          wr_mode,
  input  logic          wr_tcr,
  input  logic          wr_selen,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] odr_q,
  output logic [DW-1:0] icr_q,
  output logic [DW-1:0] mode_q,
  output logic [PW-1:0] tcr_q,
  output logic [DW-1:0] selen_q
);
  // control bits 6 and 5 are read-only status, never stored
  localparam logic [DW-1:0] ICR_WMASK = ~(DW'(2'b11) << 5);

  always_ff @(posedge clk) begin
    if (rst) begin
      odr_q   <= '0;
      icr_q   <= '0;
      mode_q  <= '0;
      tcr_q   <= '0;
      selen_q <= '0;
    end else begin
      if (wr_odr)   odr_q   <= wdata;
      if (wr_icr)   icr_q   <= wdata & ICR_WMASK;
      if (wr_mode)  mode_q  <= wdata;
      if (wr_tcr)   tcr_q   <= wdata[PW-1:0];
      if (wr_selen) selen_q <= wdata;
    end
  end
endmodule

// File: rtl/scsi_ini_dma.sv
module scsi_ini_dma
  import scsi_ini_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pm,
  input  logic          req,
  input  logic [DW-1:0] db,
  input  logic          dbp,
  input  logic          start_rx,
  input  logic          start_tx,
  input  logic          dma_off,
  input  logic          rd_idr,
  input  logic          wr_odr,
  input  logic          par_en,
  input  logic          block,
  output logic [DW-1:0] idr_q,
  output logic          drq,
  output logic          dma_ack,
  output logic          tx_drive,
  output logic          busy,
  output logic          end_q,
  output logic          mis_stop,
  output logic          par_bad
);
  dma_st_t       st, st_n;
  logic          full, full_n, end_n, latch;
  logic [DW-1:0] idr_n;
  logic          rx_role, tx_role;

  assign rx_role = (st == ST_RX_WAIT) || (st == ST_RX_ACK);
  assign tx_role = (st == ST_TX_WAIT) || (st == ST_TX_ACK);

  always_comb begin
    st_n     = st;
    full_n   = full;
    idr_n    = idr_q;
    end_n    = end_q;
    latch    = 1'b0;
    mis_stop = 1'b0;
    if (rd_idr && rx_role) full_n = 1'b0;
    if (wr_odr && tx_role) full_n = 1'b1;
    if (st != ST_IDLE) begin
      if (dma_off) begin
        st_n   = ST_IDLE;
        full_n = 1'b0;
        end_n  = 1'b1;
      end else if (!pm) begin
        st_n     = ST_IDLE;
        full_n   = 1'b0;
        mis_stop = 1'b1;
      end else begin
        case (st)
          ST_RX_WAIT: if (req && !full) begin
            st_n   = ST_RX_ACK;
            full_n = 1'b1;
            idr_n  = db;
            latch  = 1'b1;
          end
          ST_RX_ACK:  if (!req) st_n = ST_RX_WAIT;
          ST_TX_WAIT: if (req && full) st_n = ST_TX_ACK;
          ST_TX_ACK:  if (!req) begin
            st_n   = ST_TX_WAIT;
            full_n = 1'b0;
          end
          default: ;
        endcase
      end
    end
    if (start_rx) begin
      st_n   = ST_RX_WAIT;
      full_n = 1'b0;
      end_n  = 1'b0;
    end else if (start_tx) begin
      st_n   = ST_TX_WAIT;
      full_n = 1'b0;
      end_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      full  <= 1'b0;
      idr_q <= '0;
      end_q <= 1'b0;
    end else begin
      st    <= st_n;
      full  <= full_n;
      idr_q <= idr_n;
      end_q <= end_n;
    end
  end

  // odd parity expected over data plus parity line
  assign par_bad  = latch && par_en && !(^{dbp, db});
  assign busy     = (st != ST_IDLE);
  assign dma_ack  = (st == ST_RX_ACK) || (st == ST_TX_ACK);
  assign tx_drive = tx_role;
  assign drq      = block ? busy : (rx_role ? full : (tx_role ? !full : 1'b0));
endmodule

// File: rtl/scsi_ini_irq.sv
module scsi_ini_irq (
  input  logic clk,
  input  logic rst,
  input  logic sel_hit,
  input  logic bsy,
  input  logic mon_en,
  input  logic par_bad,
  input  logic par_int_en,
  input  logic mis_stop,
  input  logic clr,
  output logic irq_q,
  output logic perr_q,
  output logic berr_q,
  output logic irq_set
);
  logic bsy_q, bsy_fall;

  assign bsy_fall = mon_en && bsy_q && !bsy;
  assign irq_set  = sel_hit || bsy_fall || (par_bad && par_int_en) || mis_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      bsy_q  <= 1'b0;
      irq_q  <= 1'b0;
      perr_q <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      bsy_q  <= bsy;
      irq_q  <= irq_set  || (irq_q  && !clr);
      perr_q <= par_bad  || (perr_q && !clr);
      berr_q <= bsy_fall || (berr_q && !clr);
    end
  end
endmodule

// File: rtl/scsi_ini_regs.sv
module scsi_ini_regs
  import scsi_ini_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  input  logic          hst_wr,
  input  logic          hst_rd,
  output logic [DW-1:0] hst_rdata,
  output logic          irq,
  output logic          drq,
  input  logic [DW-1:0] bus_db_in,
  input  logic          bus_dbp_in,
  input  logic          bus_rst_in,
  input  logic          bus_bsy_in,
  input  logic          bus_sel_in,
  input  logic          bus_atn_in,
  input  logic          bus_ack_in,
  input  logic          bus_req_in,
  input  logic          bus_msg_in,
  input  logic          bus_cd_in,
  input  logic          bus_io_in,
  output logic [DW-1:0] db_out,
  output logic          dbp_out,
  output logic          db_oe,
  output logic          rst_o,
  output logic          bsy_o,
  output logic          sel_o,
  output logic          atn_o,
  output logic          ack_o
);
  localparam int NREG = 1 << AW;

  logic [NREG-1:0] wr_hit, rd_hit;
  logic [DW-1:0]   odr_q, icr_q, mode_q, selen_q, idr_q;
  logic [PW-1:0]   tcr_q;
  logic            pm, sel_hit, tx_drive, dma_ack, dma_busy, end_q;
  logic            mis_stop, par_bad, perr_q, berr_q, irq_set;
  logic [DW-1:0]   icr_rd, stat_rd, bstat_rd;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_hit[i] = hst_wr && (hst_addr == AW'(i));
    assign rd_hit[i] = hst_rd && (hst_addr == AW'(i));
  end

  scsi_ini_hostregs #(.DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_odr(wr_hit[A_DATA]), .wr_icr(wr_hit[A_ICMD]), .wr_mode(wr_hit[A_MODE]),
    .wr_tcr(wr_hit[A_TCMD]), .wr_selen(wr_hit[A_STAT]), .wdata(hst_wdata),
    .odr_q(odr_q), .icr_q(icr_q), .mode_q(mode_q), .tcr_q(tcr_q), .selen_q(selen_q)
  );

  assign pm      = ({bus_msg_in, bus_cd_in, bus_io_in} == tcr_q[2:0]);
  assign sel_hit = !bus_bsy_in && bus_sel_in && ((bus_db_in & selen_q) != '0);

  scsi_ini_dma #(.DW(DW)) u_dma (
    .clk(clk), .rst(rst), .pm(pm), .req(bus_req_in), .db(bus_db_in), .dbp(bus_dbp_in),
    .start_rx(wr_hit[A_CLR] && mode_q[M_DMA]),
    .start_tx(wr_hit[A_BSTAT] && mode_q[M_DMA]),
    .dma_off(wr_hit[A_MODE] && !hst_wdata[M_DMA]),
    .rd_idr(rd_hit[A_IDATA]), .wr_odr(wr_hit[A_DATA]),
    .par_en(mode_q[M_PARCHK]), .block(mode_q[M_BLOCK]),
    .idr_q(idr_q), .drq(drq), .dma_ack(dma_ack), .tx_drive(tx_drive),
    .busy(dma_busy), .end_q(end_q), .mis_stop(mis_stop), .par_bad(par_bad)
  );

  scsi_ini_irq u_irq (
    .clk(clk), .rst(rst), .sel_hit(sel_hit), .bsy(bus_bsy_in),
    .mon_en(mode_q[M_BSYMON]), .par_bad(par_bad), .par_int_en(mode_q[M_PARINT]),
    .mis_stop(mis_stop), .clr(rd_hit[A_CLR]),
    .irq_q(irq), .perr_q(perr_q), .berr_q(berr_q), .irq_set(irq_set)
  );

  assign db_out  = odr_q;
  assign dbp_out = ~^odr_q;
  assign db_oe   = mode_q[M_ARB] || (pm && (icr_q[I_DATA] || tx_drive));
  assign rst_o   = icr_q[I_RST];
  assign bsy_o   = icr_q[I_BSY];
  assign sel_o   = icr_q[I_SEL];
  assign atn_o   = icr_q[I_ATN];
  assign ack_o   = icr_q[I_ACK] || dma_ack;

  assign icr_rd   = icr_q | (DW'(mode_q[M_ARB]) << 6);
  assign stat_rd  = {bus_rst_in, bus_bsy_in, bus_req_in, bus_msg_in,
                     bus_cd_in, bus_io_in, bus_sel_in, bus_dbp_in};
  assign bstat_rd = {end_q, drq, perr_q, irq, pm, berr_q, bus_atn_in, bus_ack_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata <= '0;
    end else if (hst_rd) begin
      case (hst_addr)
        A_DATA:  hst_rdata <= bus_db_in;
        A_ICMD:  hst_rdata <= icr_rd;
        A_MODE:  hst_rdata <= mode_q;
        A_TCMD:  hst_rdata <= DW'(tcr_q);
        A_STAT:  hst_rdata <= stat_rd;
        A_BSTAT: hst_rdata <= bstat_rd;
        A_IDATA: hst_rdata <= idr_q;
        default: hst_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/scsi_ini_regs_chk.sv
module scsi_ini_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       hst_wr,
  input logic       hst_rd,
  input logic [2:0] hst_addr,
  input logic [7:0] hst_wdata,
  input logic [7:0] hst_rdata,
  input logic       irq,
  input logic       drq,
  input logic       bsy_o,
  input logic       bus_bsy_in,
  input logic       bus_sel_in,
  input logic [7:0] bus_db_in,
  input logic [7:0] selen_q,
  input logic [7:0] mode_q,
  input logic       dma_busy,
  input logic       pm,
  input logic       irq_set
);
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !hst_rd |=> $stable(hst_rdata));

  a_r5_bsy_from_write: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && hst_addr == 3'd1) |=> (bsy_o == $past(hst_wdata[3])));

  a_r6_select_irq: assert property (@(posedge clk) disable iff (rst)
    (!bus_bsy_in && bus_sel_in && ((bus_db_in & selen_q) != 8'h00)) |=> irq);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && hst_addr == 3'd7 && !irq_set) |=> !irq);

  a_r11_block_drq: assert property (@(posedge clk) disable iff (rst)
    (mode_q[7] && dma_busy) |-> drq);

  a_r12_mismatch_irq: assert property (@(posedge clk) disable iff (rst)
    (dma_busy && !pm && !(hst_wr && hst_addr == 3'd2)) |=> (irq && !dma_busy));
endmodule

bind scsi_ini_regs scsi_ini_regs_chk u_chk (
  .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
  .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq), .drq(drq), .bsy_o(bsy_o),
  .bus_bsy_in(bus_bsy_in), .bus_sel_in(bus_sel_in), .bus_db_in(bus_db_in),
  .selen_q(selen_q), .mode_q(mode_q), .dma_busy(dma_busy), .pm(pm), .irq_set(irq_set)
);

// File: tb/scsi_ini_regs_test.sv
`timescale 1ns/100ps
module scsi_ini_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [2:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0;
  logic hst_wr = 1'b0, hst_rd = 1'b0;
  logic [7:0] hst_rdata, db_out;
  logic irq, drq, dbp_out, db_oe, rst_o, bsy_o, sel_o, atn_o, ack_o;
  logic [7:0] t_db = '0;
  logic t_dbp = 0, t_rst = 0, t_bsy = 0, t_sel = 0, t_req = 0, t_msg = 0, t_cd = 0, t_io = 0;

  wire [7:0] bus_db  = t_db | (db_oe ? db_out : 8'h00);
  wire       bus_dbp = t_dbp | (db_oe & dbp_out);

  scsi_ini_regs uut (
    .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_wr(hst_wr),
    .hst_rd(hst_rd), .hst_rdata(hst_rdata), .irq(irq), .drq(drq),
    .bus_db_in(bus_db), .bus_dbp_in(bus_dbp), .bus_rst_in(t_rst | rst_o),
    .bus_bsy_in(t_bsy | bsy_o), .bus_sel_in(t_sel | sel_o), .bus_atn_in(atn_o),
    .bus_ack_in(ack_o), .bus_req_in(t_req), .bus_msg_in(t_msg), .bus_cd_in(t_cd),
    .bus_io_in(t_io), .db_out(db_out), .dbp_out(dbp_out), .db_oe(db_oe),
    .rst_o(rst_o), .bsy_o(bsy_o), .sel_o(sel_o), .atn_o(atn_o), .ack_o(ack_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: state 0 idle, 1 rx wait, 2 rx ack, 3 tx wait, 4 tx ack
  logic [7:0] m_odr, m_icr, m_mode, m_sel, m_idr, m_rdata;
  logic [3:0] m_tcr;
  int         m_st;
  logic       m_full, m_end, m_par, m_busy, m_irq, m_bsyq;

  function automatic logic f_pm();  return {t_msg, t_cd, t_io} == m_tcr[2:0]; endfunction
  function automatic logic f_tx();  return m_st == 3 || m_st == 4; endfunction
  function automatic logic f_rx();  return m_st == 1 || m_st == 2; endfunction
  function automatic logic f_oe();  return m_mode[0] | (f_pm() & (m_icr[0] | f_tx())); endfunction
  function automatic logic f_ack(); return m_icr[4] | (m_st == 2) | (m_st == 4); endfunction
  function automatic logic f_drq();
    if (m_mode[7]) return m_st != 0;
    if (f_rx()) return m_full;
    if (f_tx()) return !m_full;
    return 1'b0;
  endfunction

  always @(posedge clk) begin : model
    logic [7:0] bdb, nrd, nidr;
    logic bdbp, bbsy, p, nfull, nend, latch, mis, pbad, clr, selhit, bfall;
    int nst;
    if (rst) begin
      m_odr = 0; m_icr = 0; m_mode = 0; m_sel = 0; m_idr = 0; m_rdata = 0; m_tcr = 0;
      m_st = 0; m_full = 0; m_end = 0; m_par = 0; m_busy = 0; m_irq = 0; m_bsyq = 0;
    end else begin
      p    = f_pm();
      bdb  = t_db | (f_oe() ? m_odr : 8'h00);
      bdbp = t_dbp | (f_oe() & ~^m_odr);
      bbsy = t_bsy | m_icr[3];
      nrd  = m_rdata;
      if (hst_rd)
        case (hst_addr)
          0: nrd = bdb;
          1: nrd = m_icr | {1'b0, m_mode[0], 6'b0};
          2: nrd = m_mode;
          3: nrd = {4'b0, m_tcr};
          4: nrd = {t_rst | m_icr[7], bbsy, t_req, t_msg, t_cd, t_io, t_sel | m_icr[2], bdbp};
          5: nrd = {m_end, f_drq(), m_par, m_irq, p, m_busy, m_icr[1], f_ack()};
          6: nrd = m_idr;
          default: nrd = 0;
        endcase
      nst = m_st; nfull = m_full; nend = m_end; nidr = m_idr; latch = 0; mis = 0;
      if (hst_rd && hst_addr == 6 && f_rx()) nfull = 0;
      if (hst_wr && hst_addr == 0 && f_tx()) nfull = 1;
      if (m_st != 0) begin
        if (hst_wr && hst_addr == 2 && !hst_wdata[1]) begin nst = 0; nfull = 0; nend = 1; end
        else if (!p) begin nst = 0; nfull = 0; mis = 1; end
        else if (m_st == 1 && t_req && !m_full) begin nst = 2; nfull = 1; nidr = bdb; latch = 1; end
        else if (m_st == 2 && !t_req) nst = 1;
        else if (m_st == 3 && t_req && m_full) nst = 4;
        else if (m_st == 4 && !t_req) begin nst = 3; nfull = 0; end
      end
      if (hst_wr && m_mode[1] && hst_addr == 7) begin nst = 1; nfull = 0; nend = 0; end
      if (hst_wr && m_mode[1] && hst_addr == 5) begin nst = 3; nfull = 0; nend = 0; end
      pbad   = latch & m_mode[5] & ~(^{bdbp, bdb});
      selhit = !bbsy && (t_sel | m_icr[2]) && ((bdb & m_sel) != 0);
      bfall  = m_mode[2] && m_bsyq && !bbsy;
      clr    = hst_rd && hst_addr == 7;
      m_irq  = selhit | bfall | (pbad & m_mode[4]) | mis | (m_irq & !clr);
      m_par  = pbad | (m_par & !clr);
      m_busy = bfall | (m_busy & !clr);
      m_bsyq = bbsy;
      if (hst_wr)
        case (hst_addr)
          0: m_odr = hst_wdata;
          1: m_icr = hst_wdata & 8'h9F;
          2: m_mode = hst_wdata;
          3: m_tcr = hst_wdata[3:0];
          4: m_sel = hst_wdata;
          default: ;
        endcase
      m_st = nst; m_full = nfull; m_end = nend; m_idr = nidr; m_rdata = nrd;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 rdata", hst_rdata, m_rdata);
      chk("R8 irq", {7'b0, irq}, {7'b0, m_irq});
      chk("R11 drq", {7'b0, drq}, {7'b0, f_drq()});
      chk("R9 ack_o", {7'b0, ack_o}, {7'b0, f_ack()});
      chk("R4 db_oe", {7'b0, db_oe}, {7'b0, f_oe()});
      chk("R4 db_out", db_out, m_odr);
      chk("R5 lines", {4'b0, rst_o, bsy_o, sel_o, atn_o},
          {4'b0, m_icr[7], m_icr[3], m_icr[2], m_icr[1]});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1 hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); #1 hst_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); #1 hst_rd = 1; hst_addr = a;
    @(negedge clk); #1 hst_rd = 0; v = hst_rdata;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    cyc(3); rst = 0; cyc(1);
    chk("R1 reset rdata", hst_rdata, 8'h00);
    chk("R1 reset irq/drq", {6'b0, irq, drq}, 8'h00);
    // R1/R5 control register
    wr(1, 8'hFF); rd(1, v); chk("R1 icr readback", v, 8'h9F);
    chk("R5 bsy/rst driven", {6'b0, bsy_o, rst_o}, 8'h03);
    wr(1, 8'h10); cyc(1); chk("R5 ack from control", {7'b0, ack_o}, 8'h01);
    wr(1, 8'h00);
    wr(2, 8'h01); rd(1, v); chk("R1 arbitration bit", v, 8'h40);
    chk("R4 arbitrate drives data", {7'b0, db_oe}, 8'h01);
    wr(2, 8'h00);
    rd(7, v); chk("R1 addr7 reads zero", v, 8'h00);
    // R2 status
    t_bsy = 1; t_req = 1; t_cd = 1; t_dbp = 1;
    rd(4, v); chk("R2 status bits", v, 8'h69);
    t_bsy = 0; t_req = 0; t_cd = 0; t_dbp = 0;
    // R3/R4 phase match and data drive
    wr(0, 8'hA5); wr(3, 8'h05); t_msg = 1; t_io = 1;
    rd(5, v); chk("R3 phase match set", v, 8'h08);
    t_cd = 1; rd(5, v); chk("R3 phase match clear", v, 8'h00);
    wr(1, 8'h01); cyc(1); chk("R4 no drive on mismatch", {7'b0, db_oe}, 8'h00);
    t_cd = 0; cyc(1); chk("R4 drive on match", {7'b0, db_oe}, 8'h01);
    rd(0, v); chk("R4 bus carries latch", v, 8'hA5);
    wr(1, 8'h00); wr(3, 8'h00); t_msg = 0; t_io = 0;
    // R6 selection, R8 same-cycle set wins
    wr(4, 8'h04); t_db = 8'h02; t_sel = 1; cyc(2);
    chk("R6 unmasked id ignored", {7'b0, irq}, 8'h00);
    t_db = 8'h04; cyc(2); chk("R6 selection irq", {7'b0, irq}, 8'h01);
    rd(7, v); cyc(1); chk("R8 set wins over clear", {7'b0, irq}, 8'h01);
    t_sel = 0; t_db = 0; rd(7, v); cyc(1); chk("R8 clear", {7'b0, irq}, 8'h00);
    // R7 busy monitor
    wr(2, 8'h04); t_bsy = 1; cyc(2); t_bsy = 0; cyc(2);
    chk("R7 busy loss irq", {7'b0, irq}, 8'h01);
    rd(5, v); chk("R7 busy error flag", v, 8'h1C);
    rd(7, v); rd(5, v); chk("R8 busy flag cleared", v, 8'h08);
    wr(2, 8'h00);
    // R9 receive
    wr(3, 8'h01); t_io = 1; wr(2, 8'h02); wr(7, 8'h00);
    chk("R9 empty no drq", {7'b0, drq}, 8'h00);
    t_db = 8'h5A; t_dbp = 1; t_req = 1; cyc(2);
    chk("R9 ack and drq", {6'b0, ack_o, drq}, 8'h03);
    t_req = 0; cyc(2); chk("R9 ack released", {6'b0, ack_o, drq}, 8'h01);
    t_db = 8'h33; t_req = 1; cyc(2); chk("R9 held off while pending", {7'b0, ack_o}, 8'h00);
    rd(6, v); chk("R9 first byte", v, 8'h5A);
    cyc(2); chk("R9 second accepted", {7'b0, ack_o}, 8'h01);
    t_req = 0; rd(6, v); chk("R9 second byte", v, 8'h33);
    // R14 parity
    wr(2, 8'h32); t_db = 8'h5A; t_dbp = 0; t_req = 1; cyc(2);
    chk("R14 parity irq", {7'b0, irq}, 8'h01);
    t_req = 0; rd(5, v); chk("R14 parity flag", v, 8'h78);
    rd(7, v); rd(6, v); t_db = 0;
    // R13 end of transfer
    wr(2, 8'h00); rd(5, v); chk("R13 end flag", v, 8'h88);
    // R11 block mode
    wr(2, 8'h82); wr(7, 8'h00); chk("R11 block drq", {7'b0, drq}, 8'h01);
    rd(5, v); chk("R13 start clears end", v[7:0] & 8'h80, 8'h00);
    wr(2, 8'h00);
    wr(2, 8'h80); wr(7, 8'h00); cyc(1); chk("R9 start ignored without dma bit", {7'b0, drq}, 8'h00);
    wr(2, 8'h00);
    // R10 send
    wr(3, 8'h00); t_io = 0; wr(2, 8'h02); wr(5, 8'h00);
    chk("R10 drq when empty", {7'b0, drq}, 8'h01);
    wr(0, 8'hC3); chk("R10 loaded drops drq", {7'b0, drq}, 8'h00);
    t_req = 1; cyc(2);
    chk("R10 ack on req", {7'b0, ack_o}, 8'h01);
    chk("R10 data driven", {7'b0, db_oe}, 8'h01);
    chk("R10 data value", db_out, 8'hC3);
    t_req = 0; cyc(2); chk("R10 byte used", {6'b0, ack_o, drq}, 8'h01);
    // R12 mismatch
    t_cd = 1; cyc(2); chk("R12 mismatch", {6'b0, irq, drq}, 8'h02);
    rd(7, v); t_cd = 0; wr(2, 8'h00); cyc(2);
    done = 1;
    summary();
    $finish;
  end
endmodule